// File: doc/BRIEF.md
# PWM Input Capture Unit

This block measures an external pulse train in counter ticks. A free-running counter, fed through a programmable clock divider, is sampled by two capture channels that watch the same synchronized input. One channel captures on rising edges and the other on falling edges. An edge prescaler shared by both channels can thin the capture events to every 2nd, 4th or 8th edge of each kind.

A measurement starts with a one-cycle `start` pulse while `enable` is high. The next two rising-edge captures each raise a one-cycle pair request, which presents both capture registers together. One cycle after the second request, the unit reports the period and the high time with a valid strobe. If the second rising capture does not arrive within the programmed number of clocks, the measurement ends with a timeout flag and no result.

Top module: `pwmcap_unit`

## Requirements
- R1: After reset, `pairReq`, `resValid`, `timedOut`, `busy`, `capRise`, `capFall`, `period` and `highTime` are all zero.
- R2: While `enable` is high, the counter advances once every `clkDiv`+1 clocks and steps from 0 up to `cntMax`, then returns to 0. While `enable` is low it is held at 0.
- R3: `sigIn` passes through two synchronizing flops and a third edge-detect flop. A rising edge driven just after clock edge k loads the counter value present after edge k+2 into `capRise`. A falling edge loads `capFall` in the same way.
- R4: During a measurement, each rising-edge capture is followed one cycle later by a one-cycle `pairReq` pulse. Exactly two such pulses occur per measurement.
- R5: `period` is the difference between the two rising-edge captures of the measurement, later minus earlier. If the later value is smaller, the result is `cntMax` minus earlier plus later.
- R6: `highTime` is the falling-edge capture held at the second rising capture, minus the first rising capture, using the same wrap rule as R5.
- R7: When the value from R6 is larger than the period, the period is subtracted once from it before it is reported.
- R8: `edgeSel` values 0, 1, 2 and 3 make each channel capture on every 1st, 2nd, 4th or 8th edge of its kind. The edge counts restart on `start`.
- R9: `resValid` is a one-cycle pulse one clock after the second `pairReq`. `period` and `highTime` keep their values until the next `start`, which clears them to 0.
- R10: If the second rising capture has not occurred `tmoLimit` clocks after `start`, the measurement ends. `timedOut` is then set and held until the next `start`, `busy` drops, and no `resValid` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the counter and edge detection; `start` is ignored while low |
| start | input | 1 | One-cycle pulse that begins a measurement |
| sigIn | input | 1 | Asynchronous pulse train to measure |
| clkDiv | input | PW | Counter clock divider; the counter steps every clkDiv+1 clocks |
| edgeSel | input | 2 | Edge prescaler select: capture every 2^edgeSel edges |
| cntMax | input | CW | Highest counter value before it returns to 0 |
| tmoLimit | input | TW | Timeout in clocks from start |
| pairReq | output | 1 | One-cycle request after each rising capture in a measurement |
| capRise | output | CW | Rising-edge capture register |
| capFall | output | CW | Falling-edge capture register |
| resValid | output | 1 | One-cycle result strobe |
| period | output | CW | Measured period in counter ticks |
| highTime | output | CW | Measured high time in counter ticks |
| timedOut | output | 1 | Measurement ended without a second rising capture |
| busy | output | 1 | Measurement in progress |

## Verification
The hardest outcome to reach from the ports is the high-time correction. It needs a high time that comes out larger than the period, and that cannot happen while the signal period fits within one counter wrap. The stimulus reaches it deliberately: it sets a small counter maximum and drives a pulse train whose period is longer than one wrap, so both differences alias and the high-time difference overtakes the period. Randomized runs with small counter maxima, all divider and edge-prescaler settings, and counter phases that depend on timing then cover the wrap branch of both differences, checked against values the bench predicts from its own cycle count of every driven edge.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrMeas;   // new measurement: clear edge counts and results
    logic grabT0;    // keep first rising capture
    logic burst;     // rising capture inside a measurement
    logic latchRes;  // compute and publish the result
  } capStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } measState_t;

endpackage

// File: rtl/pwmcap_chan.sv
module pwmcap_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          edgeEv,
  input  logic          clrDiv,
  input  logic [1:0]    edgeSel,
  input  logic [CW-1:0] cntVal,
  output logic          hit,
  output logic [CW-1:0] capVal
);

  logic [2:0] divCnt;
  logic [2:0] divLast;

  always_comb begin
    divLast = 3'((4'd1 << edgeSel) - 4'd1);
    hit     = edgeEv && !clrDiv && (divCnt >= divLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      capVal <= '0;
    end else begin
      if (clrDiv)
        divCnt <= '0;
      else if (edgeEv)
        divCnt <= hit ? 3'd0 : divCnt + 3'd1;
      if (hit)
        capVal <= cntVal;
    end
  end

  // R3
  cap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> capVal == $past(cntVal));

endmodule

// File: rtl/pwmcap_dp.sv
module pwmcap_dp
  import pwmcap_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          sigIn,
  input  logic [PW-1:0] clkDiv,
  input  logic [1:0]    edgeSel,
  input  logic [CW-1:0] cntMax,
  input  capStrobe_t    stb,
  output logic          riseHit,
  output logic          pairReq,
  output logic [CW-1:0] capRise,
  output logic [CW-1:0] capFall,
  output logic          resValid,
  output logic [CW-1:0] period,
  output logic [CW-1:0] highTime
);

  localparam int NCH = 2;  // index 0 rising, 1 falling

  logic          syncA, syncB, syncC;
  logic [PW-1:0] divCnt;
  logic          tick;
  logic [CW-1:0] cnt;
  logic [NCH-1:0] evVec, hitVec;
  logic [CW-1:0] capVec [NCH];
  logic [CW-1:0] t0;
  logic [CW-1:0] perCalc, hiRaw, hiCalc;

  function automatic logic [CW-1:0] wrapDiff(input logic [CW-1:0] early,
                                             input logic [CW-1:0] late,
                                             input logic [CW-1:0] top);
    if (late >= early) return late - early;
    else               return top - early + late;
  endfunction

  // synchronizer plus edge-detect stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= sigIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign evVec[0] = enable &&  syncB && !syncC;
  assign evVec[1] = enable && !syncB &&  syncC;

  // divided free-running counter
  assign tick = enable && (divCnt >= clkDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      cnt    <= '0;
    end else if (!enable) begin
      divCnt <= '0;
      cnt    <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick)
        cnt <= (cnt >= cntMax) ? '0 : cnt + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : gChan
      pwmcap_chan #(.CW(CW)) uChan (
        .clk    (clk),
        .rstN   (rstN),
        .edgeEv (evVec[g]),
        .clrDiv (stb.clrMeas),
        .edgeSel(edgeSel),
        .cntVal (cnt),
        .hit    (hitVec[g]),
        .capVal (capVec[g])
      );
    end
  endgenerate

  assign riseHit = hitVec[0];
  assign capRise = capVec[0];
  assign capFall = capVec[1];

  always_comb begin
    perCalc = wrapDiff(t0, capVec[0], cntMax);
    hiRaw   = wrapDiff(t0, capVec[1], cntMax);
    hiCalc  = (hiRaw > perCalc) ? hiRaw - perCalc : hiRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      t0       <= '0;
      pairReq  <= 1'b0;
      resValid <= 1'b0;
      period   <= '0;
      highTime <= '0;
    end else begin
      pairReq <= stb.burst;
      if (stb.grabT0)
        t0 <= cnt;
      if (stb.clrMeas) begin
        resValid <= 1'b0;
        period   <= '0;
        highTime <= '0;
      end else begin
        resValid <= stb.latchRes;
        if (stb.latchRes) begin
          period   <= perCalc;
          highTime <= hiCalc;
        end
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(cntMax) && $past(cnt) <= $past(cntMax)) |-> cnt <= cntMax);

  // R4
  pair_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairReq |-> $past(hitVec[0]));

  // R9
  res_after_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(pairReq));

  // R9
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

endmodule

// File: rtl/pwmcap_ctrl.sv
module pwmcap_ctrl
  import pwmcap_pkg::*;
#(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          start,
  input  logic          riseHit,
  input  logic [TW-1:0] tmoLimit,
  output capStrobe_t    stb,
  output logic          timedOut,
  output logic          busy
);

  measState_t    state;
  logic [TW-1:0] tmoCnt;
  logic [TW:0]   tmoNext;
  logic          fin;
  logic          clr;

  assign clr     = start && enable;
  assign tmoNext = {1'b0, tmoCnt} + 1'b1;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    stb.clrMeas  = clr;
    stb.grabT0   = !clr && (state == ST_FIRST) && riseHit;
    stb.burst    = !clr && busy && riseHit;
    stb.latchRes = fin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tmoCnt   <= '0;
      timedOut <= 1'b0;
      fin      <= 1'b0;
    end else if (clr) begin
      state    <= ST_FIRST;
      tmoCnt   <= '0;
      timedOut <= 1'b0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (state == ST_SECOND && riseHit) begin
        state <= ST_IDLE;
        fin   <= 1'b1;
      end else if (busy) begin
        if (tmoNext >= {1'b0, tmoLimit}) begin
          state    <= ST_IDLE;
          timedOut <= 1'b1;
        end else begin
          tmoCnt <= tmoNext[TW-1:0];
          if (state == ST_FIRST && riseHit)
            state <= ST_SECOND;
        end
      end
    end
  end

  // R10
  tmo_from_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> $past(busy));

  // R10
  res_tmo_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    fin |-> !timedOut);

endmodule

// File: rtl/pwmcap_unit.sv
module pwmcap_unit
  import pwmcap_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          start,
  input  logic          sigIn,
  input  logic [PW-1:0] clkDiv,
  input  logic [1:0]    edgeSel,
  input  logic [CW-1:0] cntMax,
  input  logic [TW-1:0] tmoLimit,
  output logic          pairReq,
  output logic [CW-1:0] capRise,
  output logic [CW-1:0] capFall,
  output logic          resValid,
  output logic [CW-1:0] period,
  output logic [CW-1:0] highTime,
  output logic          timedOut,
  output logic          busy
);

  capStrobe_t stb;
  logic       riseHit;

  pwmcap_ctrl #(.TW(TW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .start   (start),
    .riseHit (riseHit),
    .tmoLimit(tmoLimit),
    .stb     (stb),
    .timedOut(timedOut),
    .busy    (busy)
  );

  pwmcap_dp #(.CW(CW), .PW(PW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .sigIn   (sigIn),
    .clkDiv  (clkDiv),
    .edgeSel (edgeSel),
    .cntMax  (cntMax),
    .stb     (stb),
    .riseHit (riseHit),
    .pairReq (pairReq),
    .capRise (capRise),
    .capFall (capFall),
    .resValid(resValid),
    .period  (period),
    .highTime(highTime)
  );

endmodule

// File: tb/pwmcap_unit_test.sv
module pwmcap_unit_test;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int TW = 24;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, start = 1'b0, sigIn = 1'b0;
  logic [PW-1:0] clkDiv = '0;
  logic [1:0]    edgeSel = '0;
  logic [CW-1:0] cntMax = 16'd999;
  logic [TW-1:0] tmoLimit = 24'd20000;
  logic          pairReq, resValid, timedOut, busy;
  logic [CW-1:0] capRise, capFall, period, highTime;

  pwmcap_unit #(.CW(CW), .PW(PW), .TW(TW)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .start(start), .sigIn(sigIn),
    .clkDiv(clkDiv), .edgeSel(edgeSel), .cntMax(cntMax), .tmoLimit(tmoLimit),
    .pairReq(pairReq), .capRise(capRise), .capFall(capFall), .resValid(resValid),
    .period(period), .highTime(highTime), .timedOut(timedOut), .busy(busy)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit mon = 0;
  int pairCnt = 0, resCnt = 0;
  int encE = 0;

  always @(negedge clk) begin
    if (mon) begin
      if (pairReq)  pairCnt++;
      if (resValid) resCnt++;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counter value captured for an edge driven after clock edge k
  function automatic int capAt(int k, int psc, int mx);
    return ((k + 2 - encE) / (psc + 1)) % (mx + 1);
  endfunction

  function automatic int wrapD(int early, int late, int mx);
    return (late >= early) ? late - early : mx - early + late;
  endfunction

  task automatic runMeas(int psc, int sel, int mx, int hi, int lo);
    int n, t0, t1, t2, expPer, expHi;
    int rs[16];
    int fs[16];
    @(negedge clk);
    enable = 1'b0;
    clkDiv = PW'(psc);
    edgeSel = 2'(sel);
    cntMax = CW'(mx);
    @(negedge clk);
    enable = 1'b1;
    encE = cyc;
    repeat (3) @(negedge clk);
    pairCnt = 0;
    resCnt = 0;
    mon = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    n = 1 << sel;
    for (int i = 0; i < 2 * n; i++) begin
      repeat (lo) @(negedge clk);
      sigIn = 1'b1;
      rs[i] = cyc;
      repeat (hi) @(negedge clk);
      sigIn = 1'b0;
      fs[i] = cyc;
    end
    repeat (8) @(negedge clk);
    mon = 0;
    t0 = capAt(rs[n-1], psc, mx);
    t2 = capAt(rs[2*n-1], psc, mx);
    t1 = capAt(fs[n-1], psc, mx);
    expPer = wrapD(t0, t2, mx);
    expHi = wrapD(t0, t1, mx);
    if (expHi > expPer) begin
      expHi = expHi - expPer;
      check("R7 corrected high time", int'(highTime), expHi);
    end else begin
      check("R6 high time", int'(highTime), expHi);
    end
    check("R5 R8 period", int'(period), expPer);
    check("R4 pair requests", pairCnt, 2);
    check("R9 result strobes", resCnt, 1);
    check("R2 R3 R8 rising capture", int'(capRise), t2);
    check("R3 falling capture", int'(capFall), capAt(fs[2*n-1], psc, mx));
    check("R10 no timeout", int'(timedOut), 0);
    repeat (5) @(negedge clk);
    check("R9 period held", int'(period), expPer);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pairReq", int'(pairReq), 0);
    check("R1 resValid", int'(resValid), 0);
    check("R1 timedOut", int'(timedOut), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 capRise", int'(capRise), 0);
    check("R1 capFall", int'(capFall), 0);
    check("R1 period", int'(period), 0);
    check("R1 highTime", int'(highTime), 0);

    runMeas(0, 0, 999, 10, 15);   // plain measurement
    runMeas(0, 0, 29, 8, 12);     // small range, wraps
    runMeas(0, 0, 99, 80, 50);    // aliased period forces the R7 correction
    runMeas(3, 2, 500, 9, 14);    // clock divider and /4 edges
    runMeas(1, 3, 2000, 5, 7);    // /8 edges
    runMeas(0, 1, 65535, 3, 2);   // minimal pulse widths

    // R10 timeout with no input activity
    tmoLimit = 24'd50;
    @(negedge clk);
    pairCnt = 0;
    resCnt = 0;
    mon = 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    check("R10 busy before timeout", int'(busy), 1);
    check("R10 not yet timed out", int'(timedOut), 0);
    repeat (40) @(negedge clk);
    mon = 0;
    check("R10 timed out", int'(timedOut), 1);
    check("R10 busy cleared", int'(busy), 0);
    check("R10 no result", resCnt, 0);
    check("R10 period cleared", int'(period), 0);
    tmoLimit = 24'd20000;

    for (int it = 0; it < 20; it++) begin
      runMeas(int'($urandom % 4), int'($urandom % 4), 20 + int'($urandom % 300),
              2 + int'($urandom % 40), 2 + int'($urandom % 40));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule